// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address that a synchronous SRAM core uses during a four-beat burst. A burst starts when either of two active-low address strobes is sampled low: the external address is captured and a small beat counter is cleared. On later edges, with both strobes high, an active-low advance input steps the beat counter. The low address bits are then formed from the captured low bits and the beat count, either by XOR (interleaved order) or by addition modulo four (linear order). The upper address bits stay at their loaded value for the whole burst.

The two strobes differ in what they sample. The processor-side strobe takes priority and ignores the byte-write qualifier on its own edge, so it always opens a burst as a read. The controller-side strobe, which only counts when the processor strobe is high, samples the byte-write qualifier on its edge, so it can open a write burst. Once a burst is in write mode, an advance only takes effect on edges where a byte select is also low. Edges with no byte select hold the address. The order-select pin is a static strap and is read live. The address appears on the output one cycle after the edge that loads or steps it.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `burst_addr` is 0.
- R2: An edge with `proc_strb_n` low loads `ext_addr`, which appears on `burst_addr` one cycle later, whatever `adv_n`, `wbyte_n` and `ctrl_strb_n` are on that edge.
- R3: An edge with `ctrl_strb_n` low and `proc_strb_n` high loads `ext_addr`, which appears on `burst_addr` one cycle later.
- R4: An edge with both strobes high and `adv_n` low steps the beat count by one in a read burst.
- R5: An edge with both strobes high and `adv_n` high leaves `burst_addr` unchanged.
- R6: With `ilv_sel` high, the low two bits of `burst_addr` equal the loaded low bits XOR the beat count (0,1,2,3).
- R7: With `ilv_sel` low, the low two bits equal the loaded low bits plus the beat count, modulo 4.
- R8: The bits of `burst_addr` above bit 1 change only on a load edge.
- R9: A burst is a write burst if `wbyte_n` is low on the controller-strobe load edge, or on any later edge with both strobes high. In a write burst an advance edge steps only when `wbyte_n` is also low. Otherwise the address holds.
- R10: `wbyte_n` is ignored on a processor-strobe load edge. That burst stays a read burst until `wbyte_n` is sampled low on a later edge.
- R11: A load edge in mid-burst reloads the address and restarts the beat count at 0.
- R12: After four steps the beat count wraps to 0 and `burst_addr` returns to the loaded address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| proc_strb_n | input | 1 | Processor-side address strobe, active low, has priority |
| ctrl_strb_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| wbyte_n | input | 1 | Low when any byte write select is active |
| ilv_sel | input | 1 | 1 = interleaved order, 0 = linear order |
| ext_addr | input | ADDR_W | External address captured on a load edge |
| burst_addr | output | ADDR_W | Current internal burst address |

## Verification
The bench targets a linear burst that starts at low bits 3. Here a design that carries out of the low field would corrupt the upper bits instead of wrapping to 0. It also tests a write burst in which an advance arrives with no byte select: a design that ignored the qualifier would skip a beat. A processor-strobe load with a byte select low checks that such a burst is not mistaken for a write. Both strobes low together checks that the processor strobe takes priority. A restart in mid-burst checks that a design keeping the stale beat count would start at the wrong word.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  // Per-edge decisions handed from the control decode to the datapath.
  typedef struct packed {
    logic load;   // capture external address, clear beat count
    logic step;   // advance beat count by one
  } seq_cmd_t;

  // Burst kind remembered between edges.
  typedef enum logic {
    BURST_READ  = 1'b0,
    BURST_WRITE = 1'b1
  } burst_kind_e;
endpackage

// File: rtl/burst_ctl.sv
module burst_ctl
  import burst_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     proc_strb_n,
  input  logic     ctrl_strb_n,
  input  logic     adv_n,
  input  logic     wbyte_n,
  output seq_cmd_t cmd
);
  burst_kind_e kind_q, kind_d;
  logic        any_strb;

  assign any_strb = !proc_strb_n || !ctrl_strb_n;

  // Burst kind: processor strobe forces read, controller strobe samples
  // the byte qualifier, any later byte select turns the burst into a write.
  always_comb begin
    kind_d = kind_q;
    if (!proc_strb_n)      kind_d = BURST_READ;
    else if (!ctrl_strb_n) kind_d = wbyte_n ? BURST_READ : BURST_WRITE;
    else if (!wbyte_n)     kind_d = BURST_WRITE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) kind_q <= BURST_READ;
    else        kind_q <= kind_d;
  end

  always_comb begin
    cmd.load = any_strb;
    cmd.step = !any_strb && !adv_n && ((kind_d == BURST_READ) || !wbyte_n);
  end
endmodule

// File: rtl/beat_ctr.sv
module beat_ctr #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step,
  output logic [BEAT_W-1:0] beat
);
  always_ff @(posedge clk) begin
    if (!rst_n)     beat <= '0;
    else if (clear) beat <= '0;
    else if (step)  beat <= beat + 1'b1;
  end
endmodule

// File: rtl/addr_map.sv
module addr_map #(
  parameter int ADDR_W = 20,
  parameter int BEAT_W = 2
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [BEAT_W-1:0] beat,
  input  logic              ilv_sel,
  output logic [ADDR_W-1:0] addr
);
  logic [BEAT_W-1:0] lin_lo;
  logic [BEAT_W-1:0] ilv_lo;

  assign lin_lo = base[BEAT_W-1:0] + beat;

  for (genvar i = 0; i < BEAT_W; i++) begin : g_ilv
    assign ilv_lo[i] = base[i] ^ beat[i];
  end

  assign addr = {base[ADDR_W-1:BEAT_W], ilv_sel ? ilv_lo : lin_lo};
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              proc_strb_n,
  input  logic              ctrl_strb_n,
  input  logic              adv_n,
  input  logic              wbyte_n,
  input  logic              ilv_sel,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] burst_addr
);
  seq_cmd_t          cmd;
  logic [ADDR_W-1:0] base_q;
  logic [BEAT_W-1:0] beat;

  burst_ctl u_ctl (
    .clk(clk), .rst_n(rst_n),
    .proc_strb_n(proc_strb_n), .ctrl_strb_n(ctrl_strb_n),
    .adv_n(adv_n), .wbyte_n(wbyte_n), .cmd(cmd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        base_q <= '0;
    else if (cmd.load) base_q <= ext_addr;
  end

  beat_ctr #(.BEAT_W(BEAT_W)) u_beat (
    .clk(clk), .rst_n(rst_n), .clear(cmd.load), .step(cmd.step), .beat(beat)
  );

  addr_map #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_map (
    .base(base_q), .beat(beat), .ilv_sel(ilv_sel), .addr(burst_addr)
  );
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int ADDR_W = 20,
  parameter int BEAT_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              proc_strb_n,
  input logic              ctrl_strb_n,
  input logic              adv_n,
  input logic              wbyte_n,
  input logic              ilv_sel,
  input logic [ADDR_W-1:0] ext_addr,
  input logic [ADDR_W-1:0] burst_addr
);
  logic [BEAT_W-1:0] lo_inc;
  logic              idle_strb;
  assign lo_inc    = burst_addr[BEAT_W-1:0] + 1'b1;
  assign idle_strb = proc_strb_n && ctrl_strb_n;

  assert_proc_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !proc_strb_n |=> burst_addr == $past(ext_addr));

  assert_ctrl_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_strb_n && !ctrl_strb_n) |=> burst_addr == $past(ext_addr));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_strb && adv_n) |=>
      (burst_addr == $past(burst_addr) || ilv_sel != $past(ilv_sel)));

  assert_linear_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_strb && !adv_n && !wbyte_n && !ilv_sel) |=>
      (ilv_sel || burst_addr[BEAT_W-1:0] == $past(lo_inc)));

  assert_upper_fixed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    idle_strb |=> burst_addr[ADDR_W-1:BEAT_W] == $past(burst_addr[ADDR_W-1:BEAT_W]));

  assert_write_pause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_strb && !adv_n && wbyte_n &&
     $past(proc_strb_n && !ctrl_strb_n && !wbyte_n)) |=>
      (burst_addr == $past(burst_addr) || ilv_sel != $past(ilv_sel)));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .proc_strb_n(proc_strb_n), .ctrl_strb_n(ctrl_strb_n),
  .adv_n(adv_n), .wbyte_n(wbyte_n), .ilv_sel(ilv_sel), .ext_addr(ext_addr),
  .burst_addr(burst_addr)
);

// File: tb/tb_burst_addr_seq.sv
module tb_burst_addr_seq;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          proc_strb_n = 1'b1, ctrl_strb_n = 1'b1, adv_n = 1'b1, wbyte_n = 1'b1;
  logic          ilv_sel = 1'b1;
  logic [AW-1:0] ext_addr = '0;
  logic [AW-1:0] burst_addr;

  int total = 0;
  int bad = 0;

  // Behavioural reference state
  int m_base = 0, m_beat = 0;
  bit m_write = 0;
  int lfsr = 32'h1ACE5;

  always #5 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW), .BEAT_W(2)) dut (
    .clk(clk), .rst_n(rst_n), .proc_strb_n(proc_strb_n), .ctrl_strb_n(ctrl_strb_n),
    .adv_n(adv_n), .wbyte_n(wbyte_n), .ilv_sel(ilv_sel), .ext_addr(ext_addr),
    .burst_addr(burst_addr)
  );

  function automatic int expect_addr();
    int lo;
    if (ilv_sel) lo = (m_base ^ m_beat) & 3;
    else         lo = (m_base + m_beat) % 4;
    return (m_base & ~3) | lo;
  endfunction

  task automatic check(input string tag);
    int e = expect_addr();
    total++;
    if (burst_addr !== AW'(e)) begin
      bad++;
      $display("FAIL %s: burst_addr=%05h expected=%05h", tag, burst_addr, AW'(e));
    end
  endtask

  // Drive one edge, update the model after it, compare at the falling edge.
  task automatic step(input bit pn, input bit cn, input bit an, input bit bn,
                      input bit md, input int a, input string tag);
    proc_strb_n = pn; ctrl_strb_n = cn; adv_n = an; wbyte_n = bn;
    ilv_sel = md; ext_addr = AW'(a);
    @(posedge clk);
    if (!pn) begin
      m_base = a & ((1 << AW) - 1); m_beat = 0; m_write = 0;
    end else if (!cn) begin
      m_base = a & ((1 << AW) - 1); m_beat = 0; m_write = !bn;
    end else begin
      if (!bn) m_write = 1;
      if (!an && (!m_write || !bn)) m_beat = (m_beat + 1) % 4;
    end
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if (burst_addr !== '0) begin
      bad++; $display("FAIL R1: burst_addr=%05h expected=00000", burst_addr);
    end
    rst_n = 1'b1;
    @(negedge clk);
    check("R1");

    // Processor-strobe load with advance and byte select low (ignored), interleaved
    step(0, 1, 0, 0, 1, 'h12346, "R2 R10 load");
    for (int k = 0; k < 4; k++) step(1, 1, 0, 1, 1, 0, "R4 R6 R12 interleaved");
    step(1, 1, 1, 1, 1, 0, "R5 hold");
    step(1, 1, 1, 1, 1, 0, "R5 hold");
    // Linear, starting at low bits 3: wrap inside the block
    step(1, 0, 1, 1, 0, 'hABCD3, "R3 ctrl load");
    for (int k = 0; k < 4; k++) step(1, 1, 0, 1, 0, 0, "R7 R8 R12 linear wrap");
    // Write burst opened by the controller strobe
    step(1, 0, 1, 0, 0, 'h0F0F1, "R3 R9 write load");
    step(1, 1, 0, 1, 0, 0, "R9 no byte select holds");
    step(1, 1, 0, 0, 0, 0, "R9 byte select steps");
    step(1, 1, 0, 1, 1, 0, "R9 pause interleaved");
    step(1, 1, 0, 0, 1, 0, "R6 R9 write step");
    // Processor-strobe load with byte select low is still a read burst
    step(0, 1, 1, 0, 1, 'h55552, "R10 load");
    step(1, 1, 0, 1, 1, 0, "R10 read advance");
    // Mid-burst restart
    step(1, 1, 0, 1, 1, 0, "R4 advance");
    step(1, 0, 0, 1, 1, 'h77771, "R11 restart");
    step(1, 1, 0, 1, 1, 0, "R11 first beat after restart");
    // Both strobes low: processor strobe wins, burst is read
    step(0, 0, 0, 0, 0, 'h33330, "R2 both strobes");
    step(1, 1, 0, 1, 0, 0, "R2 R10 read after both");

    // Pseudo-random traffic against the model
    for (int k = 0; k < 400; k++) begin
      bit pn, cn, an, bn, md;
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB4BCD35C : 0);
      pn = (lfsr[3:0] != 0);
      cn = (lfsr[7:4] > 1);
      an = lfsr[8] & lfsr[9];
      bn = lfsr[10] | lfsr[11];
      md = (k < 200);
      step(pn, cn, an, bn, md, lfsr[27:8], "R4 R9 R11 random");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule